// File: doc/BRIEF.md
# DisplayPort Link Training Sequencer

This block trains a DisplayPort main link by walking through a clock-recovery phase and then a channel-equalization phase. It reaches the sink's configuration registers over a simple one-byte-per-transfer register handshake. It decides each step from the lane status and adjust-request bytes the sink returns. Each time the sequencer changes the transmitter's drive, it writes the new per-lane drive bytes back to the sink. It also drives the training-pattern select and the per-lane voltage-swing and pre-emphasis levels straight to the transmitter.

A run begins with a one-cycle `start` pulse that carries the requested link-rate code and lane count. The sequencer first cleans up these two values. It then goes through the power-up, configuration and pattern steps, and loops in each phase until that phase passes, a loop limit is reached, or the sink asks for a level that cannot be reached. It ends with `done` or with `fail` held high until the next start. Either way, the training pattern is switched off on both sides of the link before the block stops.

Top module: `dplt_seq`

## Requirements
- R1: After `start`, the first writes are 0x600←0x01, then 0x100←rate, then 0x101←lane count, then 0x102←0x21 (pattern 1, scrambling off), then one write 0x103+i←0x00 for each active lane i in ascending order. During this, `tx_pattern` is 1.
- R2: A requested rate code other than 0x06 or 0x0A is replaced by 0x06, and the result is limited to MAX_RATE. `link_rate` shows the value in use.
- R3: A requested lane count of 0 becomes 1 and a count above MAX_LANES becomes MAX_LANES. A remaining count of 3 becomes 2, so `lane_count` is always 1, 2 or 4.
- R4: Each training round reads status bytes 0x202 and 0x203 and adjust bytes 0x206 and 0x207, plus align byte 0x204 during equalization. Lane n uses the nibble of byte n>>1 shifted right by (n&1)*4. In an adjust nibble, bits 1:0 are the swing and bits 3:2 are the pre-emphasis.
- R5: A drive byte holds the swing in bits 1:0 and the pre-emphasis in bits 4:3. Bit 2 is set when the swing is 3, and bit 5 is set when the pre-emphasis is 3.
- R6: Clock recovery passes when status bit 0 is set for every active lane. Inactive lanes are ignored. On a pass the requested levels are applied, 0x102←0x22 is written, the drive bytes are written, and `tx_pattern` becomes 2.
- R7: If clock recovery has not passed and any active lane requests level 3 swing or pre-emphasis, training fails.
- R8: If clock recovery has not passed, each active lane whose requested levels equal its current levels increments its own counter. A lane counter reaching CR_MAX fails training. Otherwise the new levels are applied and the drive bytes are written again.
- R9: Equalization passes when bit 0 of the align byte is set and status bits 2:0 are all set on every active lane. The pattern is then switched off (0x102←0x00) and `done` rises.
- R10: During equalization, a missing clock-recovery bit on any active lane fails training.
- R11: An equalization round that does not pass writes the new drive bytes and repeats, up to EQ_MAX repeats. The next failing round fails training.
- R12: On failure, `tx_pattern` becomes 0, 0x102←0x00 is written, and then `fail` rises. `done` and `fail` are never high together.
- R13: `bus_req` stays high, with address, direction and write data unchanged, until the cycle in which `bus_ack` is high. Only one transfer is outstanding at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle pulse that begins training (accepted when idle) |
| req_rate | input | 8 | Requested link-rate code |
| req_lanes | input | 5 | Requested lane count |
| bus_req | output | 1 | Register transfer request |
| bus_we | output | 1 | 1 = write, 0 = read |
| bus_addr | output | 12 | Sink register address |
| bus_wdata | output | 8 | Write data |
| bus_ack | input | 1 | Transfer complete, one cycle |
| bus_rdata | input | 8 | Read data, valid with bus_ack |
| busy | output | 1 | Training in progress |
| done | output | 1 | Training finished successfully |
| fail | output | 1 | Training failed |
| tx_pattern | output | 2 | 0 off, 1 pattern 1, 2 pattern 2 |
| tx_swing | output | 2*MAX_LANES | Per-lane swing level, lane i at bits 2i+1:2i |
| tx_preemph | output | 2*MAX_LANES | Per-lane pre-emphasis level, lane i at bits 2i+1:2i |
| link_rate | output | 8 | Sanitized rate code in use |
| lane_count | output | 3 | Sanitized lane count in use |

## Verification
The sink model is set up for six distinct cases:
- Four lanes with one-pass phases, where mixed adjust nibbles tell apart the lane packing and field positions.
- A single lane with a bad rate code and a one-round clock-recovery retry, where the idle lanes' bits are left clear.
- A sink that repeats the same request until the clock-recovery limit is hit.
- A lane asking for level 3 during clock recovery.
- Two lanes at maximum levels that never equalize, which checks the flag bits and the equalization limit.
- Four requested-as-seven lanes that lose clock recovery during equalization.

The exact order of writes in each case separates the pass, loop and fail paths. The final flags and drive levels confirm where each run stopped.

// File: rtl/dplt_pkg.sv
package dplt_pkg;
  localparam int ADDR_W = 12;

  typedef enum logic [3:0] {
    S_IDLE, S_PWR, S_BW, S_LC, S_TP, S_LSET,
    S_RD_ST0, S_RD_ST1, S_RD_ALN, S_RD_AJ0, S_RD_AJ1,
    S_EVAL, S_DIS
  } seq_state_e;

  localparam logic [ADDR_W-1:0] A_PWR   = 12'h600;
  localparam logic [ADDR_W-1:0] A_RATE  = 12'h100;
  localparam logic [ADDR_W-1:0] A_LANES = 12'h101;
  localparam logic [ADDR_W-1:0] A_PAT   = 12'h102;
  localparam logic [ADDR_W-1:0] A_LSET0 = 12'h103;
  localparam logic [ADDR_W-1:0] A_STAT0 = 12'h202;
  localparam logic [ADDR_W-1:0] A_STAT1 = 12'h203;
  localparam logic [ADDR_W-1:0] A_ALIGN = 12'h204;
  localparam logic [ADDR_W-1:0] A_ADJ0  = 12'h206;
  localparam logic [ADDR_W-1:0] A_ADJ1  = 12'h207;

  localparam logic [7:0] PAT_TP1 = 8'h21;
  localparam logic [7:0] PAT_TP2 = 8'h22;
  localparam logic [7:0] PAT_OFF = 8'h00;
  localparam logic [7:0] PWR_D0  = 8'h01;

  function automatic logic [7:0] drive_byte(input logic [1:0] sw, input logic [1:0] pe);
    drive_byte = {2'b00, (pe == 2'd3), pe, (sw == 2'd3), sw};
  endfunction
endpackage

// File: rtl/dplt_caps.sv
module dplt_caps #(
  parameter int          MAX_LANES = 4,
  parameter logic [7:0]  MAX_RATE  = 8'h0A,
  parameter int          LCW       = 3
) (
  input  logic [7:0]     req_rate,
  input  logic [4:0]     req_lanes,
  output logic [7:0]     rate,
  output logic [LCW-1:0] lanes
);
  logic [7:0] r;
  logic [4:0] l;

  always_comb begin
    r = (req_rate == 8'h06 || req_rate == 8'h0A) ? req_rate : 8'h06;
    if (r > MAX_RATE) r = MAX_RATE;
    rate = r;
    l = req_lanes;
    if (l == 5'd0) l = 5'd1;
    if (l > 5'(MAX_LANES)) l = 5'(MAX_LANES);
    if (l == 5'd3) l = 5'd2;
    lanes = l[LCW-1:0];
  end
endmodule

// File: rtl/dplt_lane_eval.sv
module dplt_lane_eval #(
  parameter int MAX_LANES = 4,
  parameter int CR_MAX    = 5,
  parameter int CRW       = 3
) (
  input  logic [7:0]             st0,
  input  logic [7:0]             st1,
  input  logic [7:0]             aln,
  input  logic [7:0]             aj0,
  input  logic [7:0]             aj1,
  input  logic [MAX_LANES-1:0]   act,
  input  logic [2*MAX_LANES-1:0] cur_sw,
  input  logic [2*MAX_LANES-1:0] cur_pe,
  input  logic [CRW*MAX_LANES-1:0] cr_cnt,
  output logic                   cr_ok,
  output logic                   eq_ok,
  output logic                   any_l3,
  output logic                   cr_hit,
  output logic [MAX_LANES-1:0]   same,
  output logic [2*MAX_LANES-1:0] new_sw,
  output logic [2*MAX_LANES-1:0] new_pe
);
  logic [MAX_LANES-1:0] lane_cr, lane_eq, lane_l3, lane_hit;

  for (genvar i = 0; i < MAX_LANES; i++) begin : g_lane
    localparam int SH = (i % 2) * 4;
    logic [7:0] sb, ab;
    logic [3:0] sn, an;
    assign sb = ((i / 2) == 0) ? st0 : st1;
    assign ab = ((i / 2) == 0) ? aj0 : aj1;
    assign sn = sb[SH +: 4];
    assign an = ab[SH +: 4];
    assign new_sw[2*i +: 2] = an[1:0];
    assign new_pe[2*i +: 2] = an[3:2];
    assign lane_cr[i] = ~act[i] | sn[0];
    assign lane_eq[i] = ~act[i] | (sn[2:0] == 3'b111);
    assign lane_l3[i] = act[i] & ((an[1:0] == 2'd3) | (an[3:2] == 2'd3));
    assign same[i]    = act[i] & (an[1:0] == cur_sw[2*i +: 2]) & (an[3:2] == cur_pe[2*i +: 2]);
    assign lane_hit[i] = same[i] & ((cr_cnt[i*CRW +: CRW] + CRW'(1)) == CRW'(CR_MAX));
  end

  assign cr_ok  = &lane_cr;
  assign eq_ok  = aln[0] & (&lane_eq);
  assign any_l3 = |lane_l3;
  assign cr_hit = |lane_hit;
endmodule

// File: rtl/dplt_xfer.sv
module dplt_xfer #(
  parameter int AW = 12
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          go,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [7:0]    wdata,
  output logic          bus_req,
  output logic          bus_we,
  output logic [AW-1:0] bus_addr,
  output logic [7:0]    bus_wdata,
  input  logic          bus_ack,
  input  logic [7:0]    bus_rdata,
  output logic          rsp_valid,
  output logic [7:0]    rsp_data
);
  always_ff @(posedge clk) begin
    if (rst) begin
      bus_req   <= 1'b0;
      bus_we    <= 1'b0;
      bus_addr  <= '0;
      bus_wdata <= '0;
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else begin
      rsp_valid <= 1'b0;
      if (go && !bus_req) begin
        bus_req   <= 1'b1;
        bus_we    <= we;
        bus_addr  <= addr;
        bus_wdata <= wdata;
      end else if (bus_req && bus_ack) begin
        bus_req   <= 1'b0;
        rsp_valid <= 1'b1;
        rsp_data  <= bus_rdata;
      end
    end
  end
endmodule

// File: rtl/dplt_seq.sv
module dplt_seq
  import dplt_pkg::*;
#(
  parameter int         MAX_LANES = 4,
  parameter logic [7:0] MAX_RATE  = 8'h0A,
  parameter int         CR_MAX    = 5,
  parameter int         EQ_MAX    = 5,
  localparam int        LCW       = $clog2(MAX_LANES + 1)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   start,
  input  logic [7:0]             req_rate,
  input  logic [4:0]             req_lanes,
  output logic                   bus_req,
  output logic                   bus_we,
  output logic [ADDR_W-1:0]      bus_addr,
  output logic [7:0]             bus_wdata,
  input  logic                   bus_ack,
  input  logic [7:0]             bus_rdata,
  output logic                   busy,
  output logic                   done,
  output logic                   fail,
  output logic [1:0]             tx_pattern,
  output logic [2*MAX_LANES-1:0] tx_swing,
  output logic [2*MAX_LANES-1:0] tx_preemph,
  output logic [7:0]             link_rate,
  output logic [LCW-1:0]         lane_count
);
  localparam int CRW = $clog2(CR_MAX + 1);
  localparam int EQW = $clog2(EQ_MAX + 2);

  seq_state_e state;
  logic issued, ph_eq, end_ok;
  logic [7:0] tp_val;
  logic [LCW-1:0] lidx;
  logic [7:0] st0, st1, aln, aj0, aj1;
  logic [CRW*MAX_LANES-1:0] cr_cnt;
  logic [EQW-1:0] eq_cnt;
  logic [MAX_LANES-1:0] act;

  logic [7:0] cap_rate;
  logic [LCW-1:0] cap_lanes;

  logic is_acc, acc_we, go, rsp_valid;
  logic [ADDR_W-1:0] acc_addr;
  logic [7:0] acc_wdata, rsp_data;

  logic cr_ok, eq_ok, any_l3, cr_hit;
  logic [MAX_LANES-1:0] same;
  logic [2*MAX_LANES-1:0] new_sw, new_pe;

  dplt_caps #(.MAX_LANES(MAX_LANES), .MAX_RATE(MAX_RATE), .LCW(LCW)) u_caps (
    .req_rate(req_rate), .req_lanes(req_lanes), .rate(cap_rate), .lanes(cap_lanes)
  );

  dplt_lane_eval #(.MAX_LANES(MAX_LANES), .CR_MAX(CR_MAX), .CRW(CRW)) u_eval (
    .st0(st0), .st1(st1), .aln(aln), .aj0(aj0), .aj1(aj1), .act(act),
    .cur_sw(tx_swing), .cur_pe(tx_preemph), .cr_cnt(cr_cnt),
    .cr_ok(cr_ok), .eq_ok(eq_ok), .any_l3(any_l3), .cr_hit(cr_hit),
    .same(same), .new_sw(new_sw), .new_pe(new_pe)
  );

  dplt_xfer #(.AW(ADDR_W)) u_xfer (
    .clk(clk), .rst(rst), .go(go), .we(acc_we), .addr(acc_addr), .wdata(acc_wdata),
    .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_ack(bus_ack), .bus_rdata(bus_rdata), .rsp_valid(rsp_valid), .rsp_data(rsp_data)
  );

  always_comb begin
    for (int i = 0; i < MAX_LANES; i++) act[i] = (i < int'(lane_count));
  end

  always_comb begin
    is_acc    = 1'b1;
    acc_we    = 1'b1;
    acc_addr  = '0;
    acc_wdata = '0;
    case (state)
      S_PWR:    begin acc_addr = A_PWR;   acc_wdata = PWR_D0; end
      S_BW:     begin acc_addr = A_RATE;  acc_wdata = link_rate; end
      S_LC:     begin acc_addr = A_LANES; acc_wdata = 8'(lane_count); end
      S_TP:     begin acc_addr = A_PAT;   acc_wdata = tp_val; end
      S_LSET:   begin
        acc_addr  = A_LSET0 + ADDR_W'(lidx);
        acc_wdata = drive_byte(tx_swing[int'(lidx)*2 +: 2], tx_preemph[int'(lidx)*2 +: 2]);
      end
      S_RD_ST0: begin acc_we = 1'b0; acc_addr = A_STAT0; end
      S_RD_ST1: begin acc_we = 1'b0; acc_addr = A_STAT1; end
      S_RD_ALN: begin acc_we = 1'b0; acc_addr = A_ALIGN; end
      S_RD_AJ0: begin acc_we = 1'b0; acc_addr = A_ADJ0; end
      S_RD_AJ1: begin acc_we = 1'b0; acc_addr = A_ADJ1; end
      S_DIS:    begin acc_addr = A_PAT;   acc_wdata = PAT_OFF; end
      default:  is_acc = 1'b0;
    endcase
  end

  assign go   = is_acc & ~issued;
  assign busy = (state != S_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= S_IDLE;
      issued     <= 1'b0;
      ph_eq      <= 1'b0;
      end_ok     <= 1'b0;
      tp_val     <= PAT_OFF;
      lidx       <= '0;
      st0 <= '0; st1 <= '0; aln <= '0; aj0 <= '0; aj1 <= '0;
      cr_cnt     <= '0;
      eq_cnt     <= '0;
      done       <= 1'b0;
      fail       <= 1'b0;
      tx_pattern <= 2'd0;
      tx_swing   <= '0;
      tx_preemph <= '0;
      link_rate  <= 8'h06;
      lane_count <= LCW'(1);
    end else begin
      if (go) issued <= 1'b1;
      if (rsp_valid) issued <= 1'b0;
      case (state)
        S_IDLE: if (start) begin
          link_rate  <= cap_rate;
          lane_count <= cap_lanes;
          tp_val     <= PAT_TP1;
          tx_pattern <= 2'd1;
          tx_swing   <= '0;
          tx_preemph <= '0;
          cr_cnt     <= '0;
          eq_cnt     <= '0;
          ph_eq      <= 1'b0;
          done       <= 1'b0;
          fail       <= 1'b0;
          state      <= S_PWR;
        end
        S_PWR: if (rsp_valid) state <= S_BW;
        S_BW:  if (rsp_valid) state <= S_LC;
        S_LC:  if (rsp_valid) state <= S_TP;
        S_TP:  if (rsp_valid) begin lidx <= '0; state <= S_LSET; end
        S_LSET: if (rsp_valid) begin
          if (lidx == lane_count - LCW'(1)) state <= S_RD_ST0;
          else lidx <= lidx + LCW'(1);
        end
        S_RD_ST0: if (rsp_valid) begin st0 <= rsp_data; state <= S_RD_ST1; end
        S_RD_ST1: if (rsp_valid) begin st1 <= rsp_data; state <= ph_eq ? S_RD_ALN : S_RD_AJ0; end
        S_RD_ALN: if (rsp_valid) begin aln <= rsp_data; state <= S_RD_AJ0; end
        S_RD_AJ0: if (rsp_valid) begin aj0 <= rsp_data; state <= S_RD_AJ1; end
        S_RD_AJ1: if (rsp_valid) begin aj1 <= rsp_data; state <= S_EVAL; end
        S_EVAL: begin
          lidx <= '0;
          if (!ph_eq) begin
            if (cr_ok) begin
              for (int i = 0; i < MAX_LANES; i++)
                if (act[i]) begin
                  tx_swing[2*i +: 2]   <= new_sw[2*i +: 2];
                  tx_preemph[2*i +: 2] <= new_pe[2*i +: 2];
                end
              tp_val     <= PAT_TP2;
              tx_pattern <= 2'd2;
              ph_eq      <= 1'b1;
              state      <= S_TP;
            end else if (any_l3 || cr_hit) begin
              tx_pattern <= 2'd0;
              end_ok     <= 1'b0;
              state      <= S_DIS;
            end else begin
              for (int i = 0; i < MAX_LANES; i++) begin
                if (same[i]) cr_cnt[i*CRW +: CRW] <= cr_cnt[i*CRW +: CRW] + CRW'(1);
                if (act[i]) begin
                  tx_swing[2*i +: 2]   <= new_sw[2*i +: 2];
                  tx_preemph[2*i +: 2] <= new_pe[2*i +: 2];
                end
              end
              state <= S_LSET;
            end
          end else begin
            if (!cr_ok) begin
              tx_pattern <= 2'd0;
              end_ok     <= 1'b0;
              state      <= S_DIS;
            end else if (eq_ok) begin
              tx_pattern <= 2'd0;
              end_ok     <= 1'b1;
              state      <= S_DIS;
            end else if (eq_cnt >= EQW'(EQ_MAX)) begin
              tx_pattern <= 2'd0;
              end_ok     <= 1'b0;
              state      <= S_DIS;
            end else begin
              eq_cnt <= eq_cnt + EQW'(1);
              for (int i = 0; i < MAX_LANES; i++)
                if (act[i]) begin
                  tx_swing[2*i +: 2]   <= new_sw[2*i +: 2];
                  tx_preemph[2*i +: 2] <= new_pe[2*i +: 2];
                end
              state <= S_LSET;
            end
          end
        end
        S_DIS: if (rsp_valid) begin
          done  <= end_ok;
          fail  <= ~end_ok;
          state <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dplt_seq_chk.sv
module dplt_seq_chk #(
  parameter int MAX_LANES = 4,
  parameter int LCW       = 3,
  parameter int AW        = 12
) (
  input logic           clk,
  input logic           rst,
  input logic           bus_req,
  input logic           bus_ack,
  input logic           bus_we,
  input logic [AW-1:0]  bus_addr,
  input logic [7:0]     bus_wdata,
  input logic           done,
  input logic           fail,
  input logic [1:0]     tx_pattern,
  input logic [7:0]     link_rate,
  input logic [LCW-1:0] lane_count
);
  // R13: request held with stable fields until acknowledged
  p_req_hold_r13: assert property (@(posedge clk) disable iff (rst)
    (bus_req && !bus_ack) |=> (bus_req && $stable(bus_addr) && $stable(bus_we) && $stable(bus_wdata)));

  // R13: request drops after acknowledge, so one transfer at a time
  p_req_drop_r13: assert property (@(posedge clk) disable iff (rst)
    (bus_req && bus_ack) |=> !bus_req);

  p_done_fail_excl_r12: assert property (@(posedge clk) disable iff (rst)
    !(done && fail));

  p_fail_pat_off_r12: assert property (@(posedge clk) disable iff (rst)
    $rose(fail) |-> (tx_pattern == 2'd0));

  p_pat_legal_r6: assert property (@(posedge clk) disable iff (rst)
    tx_pattern != 2'd3);

  p_lanes_legal_r3: assert property (@(posedge clk) disable iff (rst)
    ($countones(lane_count) == 1) && (int'(lane_count) <= MAX_LANES));

  p_rate_legal_r2: assert property (@(posedge clk) disable iff (rst)
    (link_rate == 8'h06) || (link_rate == 8'h0A));
endmodule

bind dplt_seq dplt_seq_chk #(.MAX_LANES(MAX_LANES), .LCW(LCW), .AW(dplt_pkg::ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .bus_req(bus_req), .bus_ack(bus_ack), .bus_we(bus_we),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .done(done), .fail(fail),
  .tx_pattern(tx_pattern), .link_rate(link_rate), .lane_count(lane_count)
);

// File: tb/dplt_seq_tb_top.sv
`timescale 1ns/1ps
module dplt_seq_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic [7:0] req_rate = 8'h06;
  logic [4:0] req_lanes = 5'd1;
  logic bus_req, bus_we, bus_ack;
  logic [11:0] bus_addr;
  logic [7:0] bus_wdata, bus_rdata;
  logic busy, done, fail;
  logic [1:0] tx_pattern;
  logic [7:0] tx_swing, tx_preemph, link_rate;
  logic [2:0] lane_count;

  always #10 clk = ~clk;

  dplt_seq dut_i (
    .clk(clk), .rst(rst), .start(start), .req_rate(req_rate), .req_lanes(req_lanes),
    .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_ack(bus_ack), .bus_rdata(bus_rdata), .busy(busy), .done(done), .fail(fail),
    .tx_pattern(tx_pattern), .tx_swing(tx_swing), .tx_preemph(tx_preemph),
    .link_rate(link_rate), .lane_count(lane_count)
  );

  int n_cmp = 0;
  int n_bad = 0;
  logic [19:0] expq[$];

  // sink model settings
  logic [7:0] sk_adj0, sk_adj1, sk_crv, sk_eqv, sk_tp;
  int sk_cr_need, sk_eq_need, sk_cr_rd, sk_eq_rd;
  bit sk_eq_lost;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic push(input logic [11:0] a, input logic [7:0] d);
    expq.push_back({a, d});
  endtask

  function automatic logic [7:0] db(input logic [1:0] sw, input logic [1:0] pe);
    db = {2'b00, (pe == 2'd3), pe, (sw == 2'd3), sw};
  endfunction

  task automatic exp_start(input logic [7:0] rate, input int lanes);
    push(12'h600, 8'h01);
    push(12'h100, rate);
    push(12'h101, 8'(lanes));
    push(12'h102, 8'h21);
    for (int i = 0; i < lanes; i++) push(12'h103 + 12'(i), 8'h00);
  endtask

  function automatic logic [7:0] sk_status();
    if (sk_tp == 8'h21) return (sk_cr_rd > sk_cr_need) ? sk_crv : 8'h00;
    if (sk_eq_lost) return 8'h00;
    return (sk_eq_rd > sk_eq_need) ? sk_eqv : sk_crv;
  endfunction

  // sink / monitor: serves transfers and scores every write against the queue
  initial begin
    logic [11:0] a0;
    logic [19:0] e;
    bus_ack = 1'b0;
    bus_rdata = 8'h00;
    forever begin
      @(negedge clk);
      if (bus_req) begin
        a0 = bus_addr;
        repeat (2) @(negedge clk);
        chk("R13 address held until ack", {20'd0, bus_addr}, {20'd0, a0});
        if (bus_we) begin
          if (bus_addr == 12'h102) sk_tp = bus_wdata;
          if (expq.size() == 0) begin
            chk("R1 unexpected write", {bus_addr, bus_wdata}, 32'hFFFFF);
          end else begin
            e = expq.pop_front();
            chk("R1/R6/R8/R11/R12 write sequence", {12'd0, bus_addr, bus_wdata}, {12'd0, e});
          end
        end else begin
          case (bus_addr)
            12'h202: begin
              if (sk_tp == 8'h21) sk_cr_rd++; else sk_eq_rd++;
              bus_rdata = sk_status();
            end
            12'h203: bus_rdata = sk_status();
            12'h204: bus_rdata = (!sk_eq_lost && sk_eq_rd > sk_eq_need) ? 8'h01 : 8'h00;
            12'h206: bus_rdata = sk_adj0;
            12'h207: bus_rdata = sk_adj1;
            default: bus_rdata = 8'h00;
          endcase
        end
        bus_ack = 1'b1;
        @(negedge clk);
        bus_ack = 1'b0;
      end
    end
  end

  task automatic setup(input logic [7:0] a0, input logic [7:0] a1, input int crn,
                       input logic [7:0] crv, input int eqn, input logic [7:0] eqv, input bit lost);
    sk_adj0 = a0; sk_adj1 = a1; sk_cr_need = crn; sk_crv = crv;
    sk_eq_need = eqn; sk_eqv = eqv; sk_eq_lost = lost;
    sk_cr_rd = 0; sk_eq_rd = 0; sk_tp = 8'h00;
  endtask

  task automatic run_case(input logic [7:0] rate, input logic [4:0] lanes);
    @(negedge clk);
    req_rate = rate; req_lanes = lanes; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (!(done || fail)) @(negedge clk);
    repeat (3) @(negedge clk);
    chk("R1 all expected writes seen", expq.size(), 0);
    chk("R12 pattern off at end", {30'd0, tx_pattern}, 0);
  endtask

  initial begin
    int cyc = 0;
    while (cyc < 150000) begin @(posedge clk); cyc++; end
    n_cmp++; n_bad++;
    $display("FAIL R13 watchdog actual=hung expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    setup(8'h00, 8'h00, 0, 8'h11, 0, 8'h77, 1'b0);
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("reset done", done, 0);
    chk("reset fail", fail, 0);
    chk("reset bus_req", bus_req, 0);
    chk("reset busy", busy, 0);
    chk("reset tx_pattern", tx_pattern, 0);

    // S1: four lanes, one-pass phases, mixed adjust nibbles (R4, R5, R6, R9)
    setup(8'h21, 8'h84, 0, 8'h11, 0, 8'h77, 1'b0);
    exp_start(8'h0A, 4);
    push(12'h102, 8'h22);
    push(12'h103, db(1, 0)); push(12'h104, db(2, 0));
    push(12'h105, db(0, 1)); push(12'h106, db(0, 2));
    push(12'h102, 8'h00);
    run_case(8'h0A, 5'd4);
    chk("R9 done", done, 1);
    chk("R9 not fail", fail, 0);
    chk("R2 rate kept", link_rate, 8'h0A);
    chk("R4 swing per lane", tx_swing, 8'h09);
    chk("R4 preemph per lane", tx_preemph, 8'h90);

    // S2: bad rate, zero lanes, one CR retry, idle lane bits clear (R2, R3, R6, R8)
    setup(8'h05, 8'h00, 1, 8'h01, 0, 8'h07, 1'b0);
    exp_start(8'h06, 1);
    push(12'h103, db(1, 1));
    push(12'h102, 8'h22);
    push(12'h103, db(1, 1));
    push(12'h102, 8'h00);
    run_case(8'h14, 5'd0);
    chk("R2 rate fallback", link_rate, 8'h06);
    chk("R3 zero lanes to one", lane_count, 1);
    chk("R6 single-lane done", done, 1);

    // S3: unchanged requests until CR limit (R8)
    setup(8'h00, 8'h00, 1000, 8'h11, 0, 8'h77, 1'b0);
    exp_start(8'h0A, 2);
    for (int k = 0; k < 4; k++) begin push(12'h103, 8'h00); push(12'h104, 8'h00); end
    push(12'h102, 8'h00);
    run_case(8'h0A, 5'd2);
    chk("R8 cr loop limit fail", fail, 1);
    chk("R8 not done", done, 0);

    // S4: level 3 requested during CR (R7)
    setup(8'h03, 8'h00, 1000, 8'h11, 0, 8'h77, 1'b0);
    exp_start(8'h0A, 1);
    push(12'h102, 8'h00);
    run_case(8'h0A, 5'd1);
    chk("R7 level3 fail", fail, 1);

    // S5: 3 lanes -> 2, max levels, never equalizes (R3, R5, R11)
    setup(8'h3C, 8'h00, 0, 8'h11, 1000, 8'h77, 1'b0);
    exp_start(8'h06, 2);
    push(12'h102, 8'h22);
    for (int k = 0; k < 6; k++) begin push(12'h103, 8'h38); push(12'h104, 8'h07); end
    push(12'h102, 8'h00);
    run_case(8'h06, 5'd3);
    chk("R3 three lanes to two", lane_count, 2);
    chk("R11 eq loop limit fail", fail, 1);
    chk("R5 swing levels", tx_swing, 8'h0C);
    chk("R5 preemph levels", tx_preemph, 8'h03);

    // S6: 7 lanes -> 4, CR lost during EQ (R3, R10)
    setup(8'h00, 8'h00, 0, 8'h11, 0, 8'h77, 1'b1);
    exp_start(8'h06, 4);
    push(12'h102, 8'h22);
    for (int i = 0; i < 4; i++) push(12'h103 + 12'(i), 8'h00);
    push(12'h102, 8'h00);
    run_case(8'h06, 5'd7);
    chk("R3 lanes clamped to max", lane_count, 4);
    chk("R10 cr lost fail", fail, 1);
    chk("R12 done low on fail", done, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule